// File: doc/BRIEF.md
# Peripheral Interrupt Flag Register

This block gathers single-cycle event pulses from eight peripheral sources into one 8-bit flag register that a CPU can read and write over a simple bus. Six of the bits are sticky. A source event sets the bit, and the bit stays set until software writes 0 to it. The other two bits are read-only. They follow the level state of a serial receive buffer (holding data) and a serial transmit buffer (empty). Those two bits clear when the peripheral's own buffer is accessed. This register does not clear them.

The register is paired with an 8-bit enable mask and a global enable. From these it raises a single interrupt request. A parameter selects a reduced-pin variant. In that variant the top bit is reserved: it reads as 0 and can never become 1.

Top module: `perif_irq_flags`

## Requirements
- R1: Bit positions are: 7 parallel port access, 6 ADC done, 5 receive buffer full, 4 transmit buffer empty, 3 synchronous serial done, 2 capture/compare, 1 timer2 period match, 0 timer1 overflow. During and after reset every sticky bit is 0.
- R2: An event pulse on a sticky source sets its bit at the next clock edge. This holds whatever the values of `enMask` and `globalEn`.
- R3: A sticky bit stays 1 with no further event until a bus write (`busSel` and `busWe` high) puts 0 in that bit position. The bit then reads 0 after that clock edge.
- R4: A bus write of 1 to a sticky bit sets it, which gives a software-raised interrupt.
- R5: Bit 5 reads the current value of `rxFull` and bit 4 reads the current value of `txEmpty`. Bus writes to bits 5 and 4 have no effect on them.
- R6: When an event pulse and a bus write of 0 reach the same bit in the same cycle, the bit is 1 after that edge.
- R7: `evtCcp` is ignored while `ccpPwmMode` is 1, and it sets bit 2 when `ccpPwmMode` is 0.
- R8: With `REDUCED_PINS`=1, bit 7 always reads 0. Neither `evtPort` nor a bus write of 1 can set it.
- R9: `irqOut` is 1 exactly when `globalEn` is 1 and the bitwise AND of `busRdata` and `enMask` is nonzero. It responds in the same cycle to changes of `enMask`, `globalEn` and the level inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Register selected by the bus |
| busWe | input | 1 | Write strobe, qualified by busSel |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Current flag value (always driven) |
| evtPort | input | 1 | Parallel port read/write event pulse |
| evtAdc | input | 1 | ADC conversion done pulse |
| evtSync | input | 1 | Synchronous serial transfer done pulse |
| evtCcp | input | 1 | Capture or compare match pulse |
| ccpPwmMode | input | 1 | Capture/compare unit is in PWM mode |
| evtTmr2 | input | 1 | Timer2-to-period match pulse |
| evtTmr1 | input | 1 | Timer1 overflow pulse |
| rxFull | input | 1 | Receive buffer holds data (level) |
| txEmpty | input | 1 | Transmit buffer is empty (level) |
| enMask | input | 8 | Per-bit interrupt enable |
| globalEn | input | 1 | Global interrupt enable |
| irqOut | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a bus clear and a source event that hit the same bit on the same edge. The stimulus drives both in one cycle. It does this for one bit, and at the same time it clears the other sticky bits, so the bench sees the event win on that bit and the clear take effect everywhere else. Two instances run on the same stimulus, one full and one reduced-pin. The reserved bit is then checked against the same events and writes that do set it in the full variant.

// File: rtl/perif_irq_pkg.sv
package perif_irq_pkg;
  localparam int FLAG_W = 8;

  localparam int BIT_PORT = 7;
  localparam int BIT_ADC  = 6;
  localparam int BIT_RX   = 5;
  localparam int BIT_TX   = 4;
  localparam int BIT_SYNC = 3;
  localparam int BIT_CCP  = 2;
  localparam int BIT_TMR2 = 1;
  localparam int BIT_TMR1 = 0;

  // strobes from control to datapath
  typedef struct packed {
    logic              wrStb;
    logic [FLAG_W-1:0] wrVal;
    logic [FLAG_W-1:0] setVec;
  } flagStb_t;

  function automatic logic [FLAG_W-1:0] stickyMask(input bit reduced);
    logic [FLAG_W-1:0] m;
    m = '1;
    m[BIT_RX] = 1'b0;
    m[BIT_TX] = 1'b0;
    if (reduced) m[BIT_PORT] = 1'b0;
    return m;
  endfunction
endpackage

// File: rtl/perif_irq_ctrl.sv
module perif_irq_ctrl
  import perif_irq_pkg::*;
#(
  parameter logic [FLAG_W-1:0] STICKY_MASK = 8'hCF
) (
  input  logic              busSel,
  input  logic              busWe,
  input  logic [FLAG_W-1:0] busWdata,
  input  logic              evtPort,
  input  logic              evtAdc,
  input  logic              evtSync,
  input  logic              evtCcp,
  input  logic              ccpPwmMode,
  input  logic              evtTmr2,
  input  logic              evtTmr1,
  output flagStb_t          stb
);
  logic [FLAG_W-1:0] rawEvt;

  always_comb begin
    rawEvt           = '0;
    rawEvt[BIT_PORT] = evtPort;
    rawEvt[BIT_ADC]  = evtAdc;
    rawEvt[BIT_SYNC] = evtSync;
    rawEvt[BIT_CCP]  = evtCcp & ~ccpPwmMode;  // no capture/compare events in PWM mode
    rawEvt[BIT_TMR2] = evtTmr2;
    rawEvt[BIT_TMR1] = evtTmr1;
  end

  always_comb begin
    stb.wrStb  = busSel & busWe;
    stb.wrVal  = busWdata & STICKY_MASK;
    stb.setVec = rawEvt & STICKY_MASK;
  end
endmodule

// File: rtl/perif_irq_dp.sv
module perif_irq_dp
  import perif_irq_pkg::*;
#(
  parameter logic [FLAG_W-1:0] STICKY_MASK = 8'hCF
) (
  input  logic              clk,
  input  logic              rstN,
  input  flagStb_t          stb,
  input  logic              rxFull,
  input  logic              txEmpty,
  input  logic [FLAG_W-1:0] enMask,
  input  logic              globalEn,
  output logic [FLAG_W-1:0] flagsRd,
  output logic              irqOut
);
  logic [FLAG_W-1:0] sticky;
  logic [FLAG_W-1:0] levels;

  for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
    if (STICKY_MASK[i]) begin : g_flop
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          sticky[i] <= 1'b0;
        else if (stb.setVec[i])
          sticky[i] <= 1'b1;          // event beats a same-cycle clear
        else if (stb.wrStb)
          sticky[i] <= stb.wrVal[i];
      end
    end else begin : g_none
      assign sticky[i] = 1'b0;
    end
  end

  always_comb begin
    levels         = '0;
    levels[BIT_RX] = rxFull;
    levels[BIT_TX] = txEmpty;
  end

  assign flagsRd = sticky | levels;
  assign irqOut  = globalEn & (|(flagsRd & enMask));
endmodule

// File: rtl/perif_irq_flags.sv
module perif_irq_flags
  import perif_irq_pkg::*;
#(
  parameter bit REDUCED_PINS = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [FLAG_W-1:0] busWdata,
  output logic [FLAG_W-1:0] busRdata,
  input  logic              evtPort,
  input  logic              evtAdc,
  input  logic              evtSync,
  input  logic              evtCcp,
  input  logic              ccpPwmMode,
  input  logic              evtTmr2,
  input  logic              evtTmr1,
  input  logic              rxFull,
  input  logic              txEmpty,
  input  logic [FLAG_W-1:0] enMask,
  input  logic              globalEn,
  output logic              irqOut
);
  localparam logic [FLAG_W-1:0] STICKY_MASK = stickyMask(REDUCED_PINS);

  flagStb_t stb;

  perif_irq_ctrl #(.STICKY_MASK(STICKY_MASK)) u_ctrl (
    .busSel(busSel), .busWe(busWe), .busWdata(busWdata),
    .evtPort(evtPort), .evtAdc(evtAdc), .evtSync(evtSync),
    .evtCcp(evtCcp), .ccpPwmMode(ccpPwmMode),
    .evtTmr2(evtTmr2), .evtTmr1(evtTmr1),
    .stb(stb)
  );

  perif_irq_dp #(.STICKY_MASK(STICKY_MASK)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .rxFull(rxFull), .txEmpty(txEmpty),
    .enMask(enMask), .globalEn(globalEn),
    .flagsRd(busRdata), .irqOut(irqOut)
  );
endmodule

// File: rtl/perif_irq_chk.sv
module perif_irq_chk #(
  parameter bit REDUCED_PINS = 1'b0
) (
  input logic       clk,
  input logic       rstN,
  input logic       busSel,
  input logic       busWe,
  input logic [7:0] busWdata,
  input logic [7:0] busRdata,
  input logic       evtAdc,
  input logic       evtCcp,
  input logic       ccpPwmMode,
  input logic       evtTmr1,
  input logic       rxFull,
  input logic       txEmpty,
  input logic [7:0] enMask,
  input logic       globalEn,
  input logic       irqOut
);
  logic wr;
  assign wr = busSel & busWe;

  // R1: sticky bits are clear while reset is held
  always_comb begin
    if (!rstN) a_r1_reset_clear: assert ((busRdata & 8'hCF) == 8'h00);
  end

  // R2 and R6: an ADC event sets bit 6 on the next edge, even against a clear
  a_r2_adc_sets: assert property (@(posedge clk) disable iff (!rstN)
    evtAdc |=> busRdata[6]);

  a_r6_event_wins: assert property (@(posedge clk) disable iff (!rstN)
    (evtTmr1 && wr && !busWdata[0]) |=> busRdata[0]);

  // R3: with no write, a set sticky bit holds
  a_r3_sticky_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busRdata[0] && !wr) |=> busRdata[0]);

  // R5: level bits follow the buffer inputs
  a_r5_level_mirror: assert property (@(posedge clk) disable iff (!rstN)
    busRdata[5:4] == {rxFull, txEmpty});

  // R7: a capture/compare pulse in PWM mode leaves a clear bit 2 clear
  a_r7_pwm_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (evtCcp && ccpPwmMode && !busRdata[2] && !wr) |=> !busRdata[2]);

  // R8: reserved bit in the reduced variant
  a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    REDUCED_PINS |-> !busRdata[7]);

  // R9: request relation at the ports
  a_r9_request: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == (globalEn && ((busRdata & enMask) != 8'h00)));
endmodule

bind perif_irq_flags perif_irq_chk #(.REDUCED_PINS(REDUCED_PINS)) u_chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe),
  .busWdata(busWdata), .busRdata(busRdata), .evtAdc(evtAdc),
  .evtCcp(evtCcp), .ccpPwmMode(ccpPwmMode), .evtTmr1(evtTmr1),
  .rxFull(rxFull), .txEmpty(txEmpty), .enMask(enMask),
  .globalEn(globalEn), .irqOut(irqOut)
);

// File: tb/perif_irq_flags_tb.sv
module perif_irq_flags_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 0, busWe = 0;
  logic [7:0] busWdata = 0;
  logic evtPort = 0, evtAdc = 0, evtSync = 0, evtCcp = 0, ccpPwmMode = 0;
  logic evtTmr2 = 0, evtTmr1 = 0, rxFull = 0, txEmpty = 0, globalEn = 0;
  logic [7:0] enMask = 0;
  logic [7:0] rdFull, rdRed;
  logic irqFull, irqRed;

  int total = 0, bad = 0;
  logic [7:0] mdl = 8'h00;          // bench model of sticky bits, full variant
  logic [17:0] expQ[$];             // {rdFull, irqFull, rdRed, irqRed}
  string tagQ[$];

  always #10 clk = ~clk;            // 50 MHz

  perif_irq_flags #(.REDUCED_PINS(1'b0)) u_dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe), .busWdata(busWdata),
    .busRdata(rdFull), .evtPort(evtPort), .evtAdc(evtAdc), .evtSync(evtSync),
    .evtCcp(evtCcp), .ccpPwmMode(ccpPwmMode), .evtTmr2(evtTmr2), .evtTmr1(evtTmr1),
    .rxFull(rxFull), .txEmpty(txEmpty), .enMask(enMask), .globalEn(globalEn),
    .irqOut(irqFull));

  perif_irq_flags #(.REDUCED_PINS(1'b1)) u_dutRed (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe), .busWdata(busWdata),
    .busRdata(rdRed), .evtPort(evtPort), .evtAdc(evtAdc), .evtSync(evtSync),
    .evtCcp(evtCcp), .ccpPwmMode(ccpPwmMode), .evtTmr2(evtTmr2), .evtTmr1(evtTmr1),
    .rxFull(rxFull), .txEmpty(txEmpty), .enMask(enMask), .globalEn(globalEn),
    .irqOut(irqRed));

  task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got rd=%02h irq=%0b, want rd=%02h irq=%0b",
               tag, act[8:1], act[0], exp[8:1], exp[0]);
    end
  endtask

  // driver: applies one cycle of stimulus and queues the expected result
  // ev bits: 7 port, 6 adc, 3 sync, 2 ccp, 1 tmr2, 0 tmr1 (5/4 unused)
  task automatic drive(input string tag, input logic [7:0] ev, input logic pwm,
                       input logic we, input logic [7:0] wd, input logic rx,
                       input logic tx, input logic [7:0] en, input logic ge);
    logic [7:0] setv, rdF, rdR;
    @(negedge clk);
    {evtPort, evtAdc, evtSync, evtCcp, evtTmr2, evtTmr1} =
      {ev[7], ev[6], ev[3], ev[2], ev[1], ev[0]};
    ccpPwmMode = pwm; busSel = we; busWe = we; busWdata = wd;
    rxFull = rx; txEmpty = tx; enMask = en; globalEn = ge;
    setv = ev & 8'hCF;
    if (pwm) setv[2] = 1'b0;
    if (we) mdl = wd & 8'hCF;
    mdl = mdl | setv;
    rdF = mdl | {2'b00, rx, tx, 4'b0000};
    rdR = rdF & 8'h7F;
    expQ.push_back({rdF, ge & (|(rdF & en)), rdR, ge & (|(rdR & en))});
    tagQ.push_back(tag);
  endtask

  // monitor: compares after each edge that has a queued expectation
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        logic [17:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check({t, " full"}, {rdFull, irqFull}, e[17:9]);
        check({t, " reduced"}, {rdRed, irqRed}, e[8:0]);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: got timeout, want completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1 in reset", {rdFull, irqFull}, 9'h000);
    check("R1 in reset red", {rdRed, irqRed}, 9'h000);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset", {rdFull, irqFull}, 9'h000);

    drive("R2 adc set, enables off", 8'h40, 0, 0, 8'h00, 0, 0, 8'hFF, 0);
    drive("R3 adc holds",            8'h00, 0, 0, 8'h00, 0, 0, 8'h40, 1);
    drive("R9 mask blocks",          8'h00, 0, 0, 8'h00, 0, 0, 8'h0F, 1);
    drive("R3 write 0 clears",       8'h00, 0, 1, 8'h00, 0, 0, 8'hFF, 1);
    drive("R4 R5 R8 write all ones", 8'h00, 0, 1, 8'hFF, 0, 0, 8'h80, 1);
    drive("R6 event beats clear",    8'h01, 0, 1, 8'h00, 0, 0, 8'h01, 1);
    drive("R7 ccp in pwm ignored",   8'h04, 1, 0, 8'h00, 0, 0, 8'h04, 1);
    drive("R7 ccp outside pwm sets", 8'h04, 0, 0, 8'h00, 0, 0, 8'h04, 1);
    drive("R5 rx level",             8'h00, 0, 1, 8'h00, 1, 0, 8'h20, 1);
    drive("R5 tx level, write 0",    8'h00, 0, 1, 8'h00, 0, 1, 8'h10, 1);
    drive("R8 port event",           8'h80, 0, 0, 8'h00, 0, 0, 8'h80, 1);
    drive("R2 all events",           8'hCF, 0, 0, 8'h00, 1, 1, 8'h00, 1);
    drive("R9 global off",           8'h00, 0, 0, 8'h00, 1, 1, 8'hFF, 0);
    drive("R9 global on",            8'h00, 0, 0, 8'h00, 0, 0, 8'h02, 1);
    drive("R3 partial clear",        8'h00, 0, 1, 8'h0A, 0, 0, 8'hFF, 1);
    drive("R5 write ignores 5/4",    8'h00, 0, 1, 8'h30, 0, 0, 8'h30, 1);
    drive("R1 idle",                 8'h00, 0, 0, 8'h00, 0, 0, 8'h00, 0);
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule